// File: doc/BRIEF.md
# Ping-Pong Bulk Endpoint Buffer

This block is the data buffer behind one bulk endpoint of a USB device. It holds two banks, each large enough for one maximum-size packet. One side of the buffer is a byte port toward the serial interface engine. The other side is a byte port toward the controller or a media DMA channel. While one bank is being filled, the other can be drained, so a stream of packets moves through without gaps.

A mode input picks the direction:
- In receive mode the serial engine writes and the controller reads.
- In transmit mode the controller writes and the serial engine reads. A filled bank stays hidden from the engine until the controller confirms that the bank's contents have passed its integrity check.
- In copy mode the controller side both writes and reads. This lets the buffer stage blocks between two media while the engine port stays idle.

Each bank is closed in one of two ways. It closes when the writer marks a byte as the last of the packet, or when the payload limit for the current bus speed is reached. The reader sees the byte count of the bank it is draining. A bank is returned to the writer only after the reader has taken exactly that many bytes.

Top module: `pingpong_ep_buf`

## Requirements
- R1: Out of reset the mode register holds receive mode and both banks are empty. In that state `sie_wr_ready` is 1 and `sie_rd_valid`, `ctl_rd_valid` and `ctl_wr_ready` are 0.
- R2: `mode` is decoded as follows:
  - 0 is receive: the engine writes and the controller reads.
  - 1 is transmit: the controller writes and the engine reads.
  - Any other value is copy: the controller writes and reads.
  - The ready and valid outputs of a direction that the mode does not use stay 0.
- R3: Banks are filled and drained alternately, starting with bank 0. Packets reach the reader in the order they were written, with bytes in write order.
- R4: A bank closes when its byte count reaches the payload limit, which is 512 when `hs` is 1 and 64 when `hs` is 0. While a bank is offered, the read count is the bank's byte count (between 1 and 512). The read-last output is 1 on exactly the final byte.
- R5: A byte written with the write-last input set closes its bank early. The reader then sees that shorter count.
- R6: While both banks hold unread data, the active write-ready output is 0. Bytes presented in that state are not stored, and the stored data is unchanged.
- R7: In transmit mode a full bank is not offered to the engine until `ctl_ok` is pulsed. Each pulse confirms the oldest full, unconfirmed bank. No confirmation is needed in receive or copy mode.
- R8: A bank becomes writable again only in the cycle after the reader takes its final byte. Taking fewer bytes leaves it held.
- R9: A cycle with `flush` high, or a cycle in which `mode` differs from the registered mode, discards both banks and points both sides at bank 0. The write side blocks and the read side offers nothing during that cycle.
- R10: In copy mode a written packet is offered on the controller read port without confirmation. Meanwhile `sie_wr_ready` and `sie_rd_valid` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 receive, 1 transmit, other values copy |
| hs | input | 1 | 1 selects the 512-byte payload limit, 0 the 64-byte limit |
| flush | input | 1 | Discard both banks |
| ctl_ok | input | 1 | Integrity confirmation pulse (transmit mode) |
| sie_wr_valid | input | 1 | Engine write byte valid |
| sie_wr_data | input | 8 | Engine write byte |
| sie_wr_last | input | 1 | Engine write byte ends the packet |
| sie_wr_ready | output | 1 | Engine write accepted |
| sie_rd_valid | output | 1 | Byte offered to engine |
| sie_rd_data | output | 8 | Byte offered to engine |
| sie_rd_last | output | 1 | Final byte of the offered bank |
| sie_rd_count | output | 10 | Byte count of the offered bank |
| sie_rd_ready | input | 1 | Engine takes the byte |
| ctl_wr_valid | input | 1 | Controller write byte valid |
| ctl_wr_data | input | 8 | Controller write byte |
| ctl_wr_last | input | 1 | Controller write byte ends the packet |
| ctl_wr_ready | output | 1 | Controller write accepted |
| ctl_rd_valid | output | 1 | Byte offered to controller |
| ctl_rd_data | output | 8 | Byte offered to controller |
| ctl_rd_last | output | 1 | Final byte of the offered bank |
| ctl_rd_count | output | 10 | Byte count of the offered bank |
| ctl_rd_ready | input | 1 | Controller takes the byte |

## Verification
The hardest situation to reach is a read bank that is only partly drained while the other bank is already full. It is the only state that shows that freeing a bank depends on the exact count rather than on any read activity. The stimulus writes two short packets back to back so that both banks fill. It then offers extra bytes to the stalled writer and drains the first packet one byte short. Write-ready is checked at that point and again after the final byte. A second hard-to-reach situation is a transmit bank that is full but unconfirmed while the other bank is also full. The bench reaches it by writing two packets before any confirmation and then issuing single `ctl_ok` pulses between drains.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic [1:0] {
        MODE_RX   = 2'd0,
        MODE_TX   = 2'd1,
        MODE_COPY = 2'd2
    } pp_mode_e;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
    parameter int DW    = 8,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
#(
    parameter int BANK_BYTES = 512,
    parameter int FS_BYTES   = 64,
    localparam int AW        = $clog2(BANK_BYTES),
    localparam int CW        = $clog2(BANK_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          hs,
    input  logic          flush,
    input  logic          confirm,
    input  logic          w_valid,
    input  logic          w_last,
    output logic          w_ready,
    output logic          w_fire,
    output logic          w_bank,
    output logic [AW-1:0] w_addr,
    input  logic          r_ready,
    output logic          r_valid,
    output logic          r_last,
    output logic [CW-1:0] r_count,
    output logic          r_bank,
    output logic [AW-1:0] r_addr
);
    typedef struct packed {
        logic [1:0]         full;
        logic [1:0]         ok;
        logic               wptr;
        logic               rptr;
        logic [CW-1:0]      wcnt;
        logic [CW-1:0]      rcnt;
        logic [1:0][CW-1:0] cnt;
        logic [1:0]         mode;
    } st_t;

    st_t s_d, s_q;
    logic clr, tx, r_fire;
    logic [CW-1:0] limit, wnext;

    always_comb begin
        s_d     = s_q;
        clr     = flush || (mode != s_q.mode);
        tx      = (mode == MODE_TX);
        limit   = hs ? CW'(BANK_BYTES) : CW'(FS_BYTES);
        wnext   = s_q.wcnt + CW'(1);
        w_ready = !clr && !s_q.full[s_q.wptr];
        w_fire  = w_valid && w_ready;
        r_valid = !clr && s_q.full[s_q.rptr] && s_q.ok[s_q.rptr];
        r_count = s_q.cnt[s_q.rptr];
        r_last  = r_valid && ((s_q.rcnt + CW'(1)) == r_count);
        r_fire  = r_valid && r_ready;

        if (clr) begin
            s_d      = '0;
            s_d.mode = mode;
        end else begin
            if (confirm && tx) begin
                if (s_q.full[s_q.rptr] && !s_q.ok[s_q.rptr])
                    s_d.ok[s_q.rptr] = 1'b1;
                else if (s_q.full[!s_q.rptr] && !s_q.ok[!s_q.rptr])
                    s_d.ok[!s_q.rptr] = 1'b1;
            end
            if (w_fire) begin
                s_d.wcnt = wnext;
                if (w_last || (wnext >= limit)) begin
                    s_d.full[s_q.wptr] = 1'b1;
                    s_d.ok[s_q.wptr]   = !tx;
                    s_d.cnt[s_q.wptr]  = wnext;
                    s_d.wcnt           = '0;
                    s_d.wptr           = !s_q.wptr;
                end
            end
            if (r_fire) begin
                if (r_last) begin
                    s_d.full[s_q.rptr] = 1'b0;
                    s_d.ok[s_q.rptr]   = 1'b0;
                    s_d.rcnt           = '0;
                    s_d.rptr           = !s_q.rptr;
                end else begin
                    s_d.rcnt = s_q.rcnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign w_bank = s_q.wptr;
    assign w_addr = s_q.wcnt[AW-1:0];
    assign r_bank = s_q.rptr;
    assign r_addr = s_q.rcnt[AW-1:0];
endmodule

// File: rtl/pingpong_ep_buf.sv
module pingpong_ep_buf
    import pp_pkg::*;
#(
    parameter int BANK_BYTES = 512,
    parameter int FS_BYTES   = 64,
    parameter int DW         = 8,
    localparam int AW        = $clog2(BANK_BYTES),
    localparam int CW        = $clog2(BANK_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          hs,
    input  logic          flush,
    input  logic          ctl_ok,
    input  logic          sie_wr_valid,
    input  logic [DW-1:0] sie_wr_data,
    input  logic          sie_wr_last,
    output logic          sie_wr_ready,
    output logic          sie_rd_valid,
    output logic [DW-1:0] sie_rd_data,
    output logic          sie_rd_last,
    output logic [CW-1:0] sie_rd_count,
    input  logic          sie_rd_ready,
    input  logic          ctl_wr_valid,
    input  logic [DW-1:0] ctl_wr_data,
    input  logic          ctl_wr_last,
    output logic          ctl_wr_ready,
    output logic          ctl_rd_valid,
    output logic [DW-1:0] ctl_rd_data,
    output logic          ctl_rd_last,
    output logic [CW-1:0] ctl_rd_count,
    input  logic          ctl_rd_ready
);
    logic sie_writes, sie_reads;
    logic w_valid, w_last, w_ready, w_fire, w_bank;
    logic r_ready, r_valid, r_last, r_bank;
    logic [AW-1:0] w_addr, r_addr;
    logic [CW-1:0] r_count;
    logic [DW-1:0] w_data;
    logic [DW-1:0] bank_rdata [2];

    assign sie_writes = (mode == MODE_RX);
    assign sie_reads  = (mode == MODE_TX);

    assign w_valid = sie_writes ? sie_wr_valid : ctl_wr_valid;
    assign w_data  = sie_writes ? sie_wr_data  : ctl_wr_data;
    assign w_last  = sie_writes ? sie_wr_last  : ctl_wr_last;
    assign r_ready = sie_reads  ? sie_rd_ready : ctl_rd_ready;

    pp_ctrl #(.BANK_BYTES(BANK_BYTES), .FS_BYTES(FS_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .hs(hs), .flush(flush),
        .confirm(ctl_ok), .w_valid(w_valid), .w_last(w_last),
        .w_ready(w_ready), .w_fire(w_fire), .w_bank(w_bank), .w_addr(w_addr),
        .r_ready(r_ready), .r_valid(r_valid), .r_last(r_last),
        .r_count(r_count), .r_bank(r_bank), .r_addr(r_addr)
    );

    for (genvar g = 0; g < 2; g++) begin : g_bank
        pp_bank #(.DW(DW), .DEPTH(BANK_BYTES)) u_bank (
            .clk(clk), .we(w_fire && (w_bank == 1'(g))), .waddr(w_addr),
            .wdata(w_data), .raddr(r_addr), .rdata(bank_rdata[g])
        );
    end

    assign sie_wr_ready = sie_writes && w_ready;
    assign ctl_wr_ready = !sie_writes && w_ready;
    assign sie_rd_valid = sie_reads && r_valid;
    assign ctl_rd_valid = !sie_reads && r_valid;
    assign sie_rd_last  = sie_reads && r_last;
    assign ctl_rd_last  = !sie_reads && r_last;
    assign sie_rd_data  = bank_rdata[r_bank];
    assign ctl_rd_data  = bank_rdata[r_bank];
    assign sie_rd_count = r_count;
    assign ctl_rd_count = r_count;
endmodule

// File: rtl/pp_buf_chk.sv
module pp_buf_chk #(
    parameter int BANK_BYTES = 512,
    parameter int DW         = 8,
    localparam int CW        = $clog2(BANK_BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          flush,
    input logic          ctl_ok,
    input logic          sie_wr_ready,
    input logic          ctl_wr_ready,
    input logic          sie_rd_valid,
    input logic [CW-1:0] sie_rd_count,
    input logic          ctl_rd_valid,
    input logic [DW-1:0] ctl_rd_data,
    input logic          ctl_rd_ready,
    input logic [CW-1:0] ctl_rd_count
);
    p_one_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sie_wr_ready && ctl_wr_ready));

    p_one_reader_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sie_rd_valid && ctl_rd_valid));

    p_sie_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sie_rd_valid |-> (sie_rd_count != 0 && sie_rd_count <= CW'(BANK_BYTES)));

    p_ctl_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_valid |-> (ctl_rd_count != 0 && ctl_rd_count <= CW'(BANK_BYTES)));

    p_tx_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && $past(mode) == 2'd1 && $rose(sie_rd_valid)) |-> $past(ctl_ok));

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!sie_rd_valid && !ctl_rd_valid));

    p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd_valid && !ctl_rd_ready && !flush) |=>
            (!$stable(mode) || flush || (ctl_rd_valid && $stable(ctl_rd_data))));
endmodule

bind pingpong_ep_buf pp_buf_chk #(.BANK_BYTES(BANK_BYTES), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .flush(flush), .ctl_ok(ctl_ok),
    .sie_wr_ready(sie_wr_ready), .ctl_wr_ready(ctl_wr_ready),
    .sie_rd_valid(sie_rd_valid), .sie_rd_count(sie_rd_count),
    .ctl_rd_valid(ctl_rd_valid), .ctl_rd_data(ctl_rd_data),
    .ctl_rd_ready(ctl_rd_ready), .ctl_rd_count(ctl_rd_count)
);

// File: tb/pingpong_ep_buf_test.sv
`timescale 1ns/1ps
module pingpong_ep_buf_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       hs = 1'b0, flush = 1'b0, ctl_ok = 1'b0;
    logic       sie_wr_valid = 1'b0, sie_wr_last = 1'b0, sie_rd_ready = 1'b0;
    logic [7:0] sie_wr_data = '0;
    logic       ctl_wr_valid = 1'b0, ctl_wr_last = 1'b0, ctl_rd_ready = 1'b0;
    logic [7:0] ctl_wr_data = '0;
    logic       sie_wr_ready, sie_rd_valid, sie_rd_last;
    logic       ctl_wr_ready, ctl_rd_valid, ctl_rd_last;
    logic [7:0] sie_rd_data, ctl_rd_data;
    logic [9:0] sie_rd_count, ctl_rd_count;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    pingpong_ep_buf uut (.*);

    function automatic logic [7:0] pat(input int base, input int i);
        return 8'(base * 31 + i * 7 + (i >> 3));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input bit by_sie, input int n, input int base, input bit with_last);
        int i = 0;
        int stall = 0;
        bit rdy;
        while (i < n && stall < 1000) begin
            @(negedge clk);
            if (by_sie) begin
                sie_wr_valid = 1'b1; sie_wr_data = pat(base, i);
                sie_wr_last = with_last && (i == n - 1);
            end else begin
                ctl_wr_valid = 1'b1; ctl_wr_data = pat(base, i);
                ctl_wr_last = with_last && (i == n - 1);
            end
            #1 rdy = by_sie ? sie_wr_ready : ctl_wr_ready;
            @(posedge clk);
            if (rdy) i++; else stall++;
        end
        if (stall >= 1000) chk(1'b0, "R6 write stuck", i, n);
        @(negedge clk);
        sie_wr_valid = 1'b0; sie_wr_last = 1'b0;
        ctl_wr_valid = 1'b0; ctl_wr_last = 1'b0;
    endtask

    task automatic pull(input bit by_sie, input int exp_cnt, input int base,
                        input int start, input int nread, input string req);
        int w = 0;
        bit v;
        do begin
            @(negedge clk);
            #1 v = by_sie ? sie_rd_valid : ctl_rd_valid;
            w++;
        end while (!v && w < 500);
        if (!v) begin
            chk(1'b0, {req, " no data offered"}, 0, 1);
            return;
        end
        for (int k = 0; k < nread; k++) begin
            @(negedge clk);
            if (by_sie) sie_rd_ready = 1'b1; else ctl_rd_ready = 1'b1;
            #1;
            if (by_sie) begin
                chk(sie_rd_valid, {req, " valid"}, int'(sie_rd_valid), 1);
                chk(sie_rd_data == pat(base, start + k), {req, " data"}, sie_rd_data, pat(base, start + k));
                chk(sie_rd_last == (start + k == exp_cnt - 1), "R4 last flag", sie_rd_last, start + k == exp_cnt - 1);
                if (k == 0) chk(sie_rd_count == 10'(exp_cnt), "R4/R5 count", sie_rd_count, exp_cnt);
            end else begin
                chk(ctl_rd_valid, {req, " valid"}, int'(ctl_rd_valid), 1);
                chk(ctl_rd_data == pat(base, start + k), {req, " data"}, ctl_rd_data, pat(base, start + k));
                chk(ctl_rd_last == (start + k == exp_cnt - 1), "R4 last flag", ctl_rd_last, start + k == exp_cnt - 1);
                if (k == 0) chk(ctl_rd_count == 10'(exp_cnt), "R4/R5 count", ctl_rd_count, exp_cnt);
            end
            @(posedge clk);
        end
        @(negedge clk);
        sie_rd_ready = 1'b0; ctl_rd_ready = 1'b0;
    endtask

    task automatic pulse_ok();
        @(negedge clk) ctl_ok = 1'b1;
        @(negedge clk) ctl_ok = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 / R2: reset state in receive mode
        chk(sie_wr_ready == 1'b1, "R1 sie_wr_ready", sie_wr_ready, 1);
        chk(ctl_rd_valid == 1'b0, "R1 ctl_rd_valid", ctl_rd_valid, 0);
        chk(ctl_wr_ready == 1'b0, "R2 ctl_wr_ready in rx", ctl_wr_ready, 0);
        chk(sie_rd_valid == 1'b0, "R2 sie_rd_valid in rx", sie_rd_valid, 0);

        // R5 / R4: sweep every short length at full speed, then the limit without last
        for (int n = 1; n <= 64; n++) begin
            push(1'b1, n, n, (n != 64));
            pull(1'b0, n, n, 0, n, "R5 sweep");
        end
        push(1'b1, 64, 99, 1'b0);
        pull(1'b0, 64, 99, 0, 64, "R4 fs limit");

        // R3 / R6 / R8: fill both banks, probe stall, drain one short of the count
        push(1'b1, 10, 3, 1'b1);
        push(1'b1, 20, 4, 1'b1);
        #1 chk(sie_wr_ready == 1'b0, "R6 ready with both full", sie_wr_ready, 0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            sie_wr_valid = 1'b1; sie_wr_data = 8'hEE; sie_wr_last = 1'b1;
        end
        @(negedge clk) begin sie_wr_valid = 1'b0; sie_wr_last = 1'b0; end
        pull(1'b0, 10, 3, 0, 9, "R3 first bank");
        #1 chk(sie_wr_ready == 1'b0, "R8 held after partial read", sie_wr_ready, 0);
        pull(1'b0, 10, 3, 9, 1, "R3 first bank tail");
        #1 chk(sie_wr_ready == 1'b1, "R8 free after final byte", sie_wr_ready, 1);
        pull(1'b0, 20, 4, 0, 20, "R6 second bank intact");

        // R4: high speed limit and a packet longer than the full-speed limit
        hs = 1'b1;
        push(1'b1, 100, 7, 1'b1);
        pull(1'b0, 100, 7, 0, 100, "R4 hs short");
        push(1'b1, 512, 8, 1'b0);
        pull(1'b0, 512, 8, 0, 512, "R4 hs limit");
        hs = 1'b0;

        // R7: transmit confirmation gating, oldest bank first
        @(negedge clk) mode = 2'd1;
        @(negedge clk);
        #1 chk(ctl_wr_ready == 1'b1, "R2 ctl_wr_ready in tx", ctl_wr_ready, 1);
        chk(sie_wr_ready == 1'b0, "R2 sie_wr_ready in tx", sie_wr_ready, 0);
        push(1'b0, 30, 11, 1'b1);
        push(1'b0, 40, 12, 1'b1);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            #1 chk(sie_rd_valid == 1'b0, "R7 withheld before confirm", sie_rd_valid, 0);
        end
        pulse_ok();
        pull(1'b1, 30, 11, 0, 30, "R7 first confirmed bank");
        #1 chk(sie_rd_valid == 1'b0, "R7 second bank unconfirmed", sie_rd_valid, 0);
        pulse_ok();
        pull(1'b1, 40, 12, 0, 40, "R7 second confirmed bank");

        // R9: flush discards a confirmed bank
        push(1'b0, 10, 13, 1'b1);
        pulse_ok();
        #1 chk(sie_rd_valid == 1'b1, "R7 offered after confirm", sie_rd_valid, 1);
        @(negedge clk) flush = 1'b1;
        @(negedge clk) flush = 1'b0;
        #1 chk(sie_rd_valid == 1'b0, "R9 flush empties", sie_rd_valid, 0);
        chk(ctl_wr_ready == 1'b1, "R9 writer free after flush", ctl_wr_ready, 1);
        push(1'b0, 5, 14, 1'b1);
        pulse_ok();
        pull(1'b1, 5, 14, 0, 5, "R9 fresh bank after flush");

        // R9 / R10: mode change clears, copy mode needs no confirmation
        @(negedge clk) mode = 2'd0;
        @(negedge clk);
        push(1'b1, 7, 15, 1'b1);
        #1 chk(ctl_rd_valid == 1'b1, "R3 rx packet offered", ctl_rd_valid, 1);
        @(negedge clk) mode = 2'd2;
        @(negedge clk);
        #1 chk(ctl_rd_valid == 1'b0, "R9 mode change empties", ctl_rd_valid, 0);
        chk(sie_wr_ready == 1'b0, "R10 engine write idle", sie_wr_ready, 0);
        chk(ctl_wr_ready == 1'b1, "R10 controller writes", ctl_wr_ready, 1);
        push(1'b0, 12, 16, 1'b1);
        #1 chk(sie_rd_valid == 1'b0, "R10 engine read idle", sie_rd_valid, 0);
        pull(1'b0, 12, 16, 0, 12, "R10 copy packet");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule